// File: doc/BRIEF.md
# Flash security and lockout recovery controller

This block settles, while reset is held, whether the on-chip flash is locked. The decision comes from a security byte that the flash presents. The locked state drives a signal that keeps the debug port from reading internal memory. The same decision, taken together with reset, decides whether a request for external boot on a pin is honoured. A locked device stays in internal boot whatever the pin says.

The only way out of the locked state is a recovery sequence driven from the debug port. A recovery instruction selects a 7-bit clock-divider register, and a value is loaded into it over the data-register port. The value overrides the normal flash clock divider. Bit 6 enables a divide-by-8 prescale, and bits 5:0 give a 6-bit divide field, so the timing period is (DIV+1) system clocks, or 8*(DIV+1) when the prescale is set. A start request then runs a timed mass-erase handshake with the flash. When the flash reports completion, the lock is cleared.

Top module: `flash_guard`

## Requirements
- R1: With rst_n low (synchronous, active low), secure_o becomes 1 unless sec_byte_i equals OPEN_CODE (default 8'h5A), in which case it becomes 0. dbg_read_block_o always equals secure_o.
- R2: boot_ext_o takes the value of boot_ext_i sampled during reset when the device is unlocked, and 0 when it is locked. It keeps that value until the next reset.
- R3: A load strobe on dbg_dr_load_i stores dbg_dr_data_i only when dbg_instr_i equals RECOV_OP (default 4'hB), the sequencer is idle, and no start is accepted in the same cycle. Under any other instruction the strobe has no effect.
- R4: div_err_o is 0 until a divider value has been stored. After that it is 1 when CLK_HZ divided by the period lies outside FMIN_HZ..FMAX_HZ (150000..200000), where the period is (bits 5:0 + 1), times 8 if bit 6 is set.
- R5: A start strobe on dbg_go_i with dbg_instr_i equal to RECOV_OP is rejected when no value has been stored since reset, or when div_err_o is 1. A rejected start raises neither erase_o nor busy_o and leaves secure_o unchanged.
- R6: After an accepted start, erase_o is high from the next cycle for exactly ERASE_TICKS times the period in system clocks.
- R7: After the erase phase the block waits for erase_done_i. erase_done_i has no effect outside this wait. The cycle after erase_done_i is sampled is a clear cycle, and secure_o and dbg_read_block_o fall on the following cycle. busy_o is high from the cycle after the start through the clear cycle.
- R8: secure_o never rises except through reset, and it falls only at the end of a clear cycle. A load strobe while busy_o is high changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sec_byte_i | input | 8 | Security byte from flash, sampled during reset |
| boot_ext_i | input | 1 | External-boot request pin, sampled during reset |
| dbg_instr_i | input | 4 | Current debug instruction |
| dbg_dr_load_i | input | 1 | Debug data-register update strobe |
| dbg_dr_data_i | input | 7 | Debug data-register value: bit 6 prescale, bits 5:0 divide |
| dbg_go_i | input | 1 | Recovery start strobe |
| erase_done_i | input | 1 | Mass-erase completion from flash |
| secure_o | output | 1 | Device is locked |
| dbg_read_block_o | output | 1 | Blocks debug reads of internal memory |
| boot_ext_o | output | 1 | External boot granted |
| div_err_o | output | 1 | Stored divider gives an out-of-range timing clock |
| erase_o | output | 1 | Mass-erase request to flash |
| busy_o | output | 1 | Recovery sequence in progress |

## Verification
The assertions assume that sec_byte_i and boot_ext_i are stable during reset, and that every input is stable around the rising clock edge. They also assume the flash raises erase_done_i only as a completion indication; any stray pulse must be ignored, not relied on. The stimulus changes inputs only on the falling edge, and it applies each strobe for a single cycle. It also places deliberate stray completion pulses inside the erase window and loads inside the busy window, so that the ignoring paths are exercised within those assumptions.

// File: rtl/flash_guard_pkg.sv
package flash_guard_pkg;

   typedef enum logic [1:0] {
      SEQ_IDLE  = 2'd0,
      SEQ_ERASE = 2'd1,
      SEQ_WAIT  = 2'd2,
      SEQ_CLEAR = 2'd3
   } seq_state_t;

   typedef struct packed {
      logic       pre8;
      logic [5:0] div;
   } clkdiv_t;

   localparam int unsigned CLKDIV_W = $bits(clkdiv_t);

endpackage

// File: rtl/fg_div_check.sv
module fg_div_check
   import flash_guard_pkg::*;
#(
   parameter int unsigned CLK_HZ      = 8_000_000,
   parameter int unsigned FMIN_HZ     = 150_000,
   parameter int unsigned FMAX_HZ     = 200_000,
   parameter int unsigned PRE_LOG2    = 3,
   parameter bit          RANGE_CHECK = 1'b1,
   localparam int unsigned PER_W      = 7 + PRE_LOG2
) (
   input  clkdiv_t           cfg,
   output logic [PER_W-1:0]  period,
   output logic              out_of_range
);

   logic [PER_W-1:0] base;

   always_comb begin
      base   = PER_W'(cfg.div) + PER_W'(1);
      period = cfg.pre8 ? (base << PRE_LOG2) : base;
   end

   generate
      if (RANGE_CHECK) begin : g_check
         logic [63:0] p64;
         logic        too_fast;
         logic        too_slow;
         always_comb begin
            p64          = 64'(period);
            too_fast     = (p64 * 64'(FMAX_HZ)) < 64'(CLK_HZ);
            too_slow     = (p64 * 64'(FMIN_HZ)) > 64'(CLK_HZ);
            out_of_range = too_fast | too_slow;
         end
      end else begin : g_nocheck
         assign out_of_range = 1'b0;
      end
   endgenerate

endmodule

// File: rtl/fg_tick_gen.sv
module fg_tick_gen #(
   parameter int unsigned PER_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic [PER_W-1:0] period,
   output logic             tick
);

   logic [PER_W-1:0] cnt_q;

   assign tick = en && (cnt_q == (period - PER_W'(1)));

   always_ff @(posedge clk) begin
      if (!rst_n || !en) begin
         cnt_q <= '0;
      end else if (tick) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + PER_W'(1);
      end
   end

endmodule

// File: rtl/fg_erase_seq.sv
module fg_erase_seq
   import flash_guard_pkg::*;
#(
   parameter int unsigned ERASE_TICKS = 4,
   localparam int unsigned TW = (ERASE_TICKS > 1) ? $clog2(ERASE_TICKS) : 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic tick,
   input  logic done,
   output logic erase,
   output logic busy,
   output logic idle,
   output logic clear
);

   seq_state_t    state_q;
   logic [TW-1:0] ticks_q;

   assign erase = (state_q == SEQ_ERASE);
   assign busy  = (state_q != SEQ_IDLE);
   assign idle  = (state_q == SEQ_IDLE);
   assign clear = (state_q == SEQ_CLEAR);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= SEQ_IDLE;
         ticks_q <= '0;
      end else begin
         unique case (state_q)
            SEQ_IDLE: begin
               ticks_q <= '0;
               if (start) state_q <= SEQ_ERASE;
            end
            SEQ_ERASE: begin
               if (tick) begin
                  if (ticks_q == TW'(ERASE_TICKS - 1)) begin
                     ticks_q <= '0;
                     state_q <= SEQ_WAIT;
                  end else begin
                     ticks_q <= ticks_q + TW'(1);
                  end
               end
            end
            SEQ_WAIT: begin
               if (done) state_q <= SEQ_CLEAR;
            end
            default: state_q <= SEQ_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/flash_guard.sv
module flash_guard
   import flash_guard_pkg::*;
#(
   parameter int unsigned CLK_HZ      = 8_000_000,
   parameter int unsigned FMIN_HZ     = 150_000,
   parameter int unsigned FMAX_HZ     = 200_000,
   parameter int unsigned PRE_LOG2    = 3,
   parameter int unsigned ERASE_TICKS = 4,
   parameter bit          RANGE_CHECK = 1'b1,
   parameter logic [7:0]  OPEN_CODE   = 8'h5A,
   parameter logic [3:0]  RECOV_OP    = 4'hB,
   localparam int unsigned PER_W      = 7 + PRE_LOG2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [7:0] sec_byte_i,
   input  logic       boot_ext_i,
   input  logic [3:0] dbg_instr_i,
   input  logic       dbg_dr_load_i,
   input  logic [6:0] dbg_dr_data_i,
   input  logic       dbg_go_i,
   input  logic       erase_done_i,
   output logic       secure_o,
   output logic       dbg_read_block_o,
   output logic       boot_ext_o,
   output logic       div_err_o,
   output logic       erase_o,
   output logic       busy_o
);

   generate
      if (ERASE_TICKS < 1) begin : g_bad_ticks
         $error("ERASE_TICKS must be at least 1");
      end
      if (FMIN_HZ > FMAX_HZ) begin : g_bad_range
         $error("FMIN_HZ must not exceed FMAX_HZ");
      end
      if (PRE_LOG2 > 8) begin : g_bad_pre
         $error("PRE_LOG2 too large");
      end
   endgenerate

   logic             secure_q;
   logic             boot_q;
   logic             loaded_q;
   clkdiv_t          cfg_q;
   logic [PER_W-1:0] period;
   logic             range_err;
   logic             tick;
   logic             seq_idle;
   logic             seq_erase;
   logic             seq_clear;
   logic             op_sel;
   logic             start_ok;
   logic             load_ok;

   assign op_sel   = (dbg_instr_i == RECOV_OP);
   assign start_ok = seq_idle && op_sel && dbg_go_i && loaded_q && !range_err;
   assign load_ok  = seq_idle && op_sel && dbg_dr_load_i && !start_ok;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         secure_q <= (sec_byte_i != OPEN_CODE);
         boot_q   <= boot_ext_i && (sec_byte_i == OPEN_CODE);
         loaded_q <= 1'b0;
         cfg_q    <= '0;
      end else begin
         if (seq_clear) secure_q <= 1'b0;
         if (load_ok) begin
            loaded_q <= 1'b1;
            cfg_q    <= clkdiv_t'(dbg_dr_data_i);
         end
      end
   end

   fg_div_check #(
      .CLK_HZ      (CLK_HZ),
      .FMIN_HZ     (FMIN_HZ),
      .FMAX_HZ     (FMAX_HZ),
      .PRE_LOG2    (PRE_LOG2),
      .RANGE_CHECK (RANGE_CHECK)
   ) i_div_check (
      .cfg          (cfg_q),
      .period       (period),
      .out_of_range (range_err)
   );

   fg_tick_gen #(
      .PER_W (PER_W)
   ) i_tick_gen (
      .clk    (clk),
      .rst_n  (rst_n),
      .en     (seq_erase),
      .period (period),
      .tick   (tick)
   );

   fg_erase_seq #(
      .ERASE_TICKS (ERASE_TICKS)
   ) i_erase_seq (
      .clk   (clk),
      .rst_n (rst_n),
      .start (start_ok),
      .tick  (tick),
      .done  (erase_done_i),
      .erase (seq_erase),
      .busy  (busy_o),
      .idle  (seq_idle),
      .clear (seq_clear)
   );

   assign secure_o         = secure_q;
   assign dbg_read_block_o = secure_q;
   assign boot_ext_o       = boot_q;
   assign div_err_o        = loaded_q && range_err;
   assign erase_o          = seq_erase;

endmodule

// File: rtl/flash_guard_chk.sv
module flash_guard_chk (
   input logic clk,
   input logic rst_n,
   input logic secure_o,
   input logic dbg_read_block_o,
   input logic boot_ext_o,
   input logic div_err_o,
   input logic erase_o,
   input logic busy_o
);

   AST_BLOCK_FOLLOWS_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
      dbg_read_block_o == secure_o);                                   // R1

   AST_LOCKED_NO_EXT_BOOT: assert property (@(posedge clk) disable iff (!rst_n)
      secure_o |-> !boot_ext_o);                                       // R2

   AST_BOOT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> $stable(boot_ext_o));                           // R2

   AST_START_NEEDS_GOOD_DIV: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $rose(erase_o)) |-> !div_err_o);                // R5

   AST_ERASE_WITHIN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      erase_o |-> busy_o);                                             // R6

   AST_UNLOCK_AFTER_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $fell(secure_o)) |-> ($past(busy_o) && !busy_o)); // R7

   AST_NO_RELOCK: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> !$rose(secure_o));                              // R8

   AST_DIVERR_FROZEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(busy_o) && busy_o) |-> $stable(div_err_o)); // R8

endmodule

bind flash_guard flash_guard_chk i_chk (
   .clk              (clk),
   .rst_n            (rst_n),
   .secure_o         (secure_o),
   .dbg_read_block_o (dbg_read_block_o),
   .boot_ext_o       (boot_ext_o),
   .div_err_o        (div_err_o),
   .erase_o          (erase_o),
   .busy_o           (busy_o)
);

// File: tb/test_flash_guard.sv
module test_flash_guard;

   localparam int CLK_PERIOD  = 10;
   localparam int CLK_HZ      = 8_000_000;
   localparam int ERASE_TICKS = 4;
   localparam logic [7:0] OPEN = 8'h5A;
   localparam logic [3:0] OP   = 4'hB;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] sec_byte = 8'h00;
   logic       boot_pin = 1'b0;
   logic [3:0] instr = 4'h0;
   logic       dr_load = 1'b0;
   logic [6:0] dr_data = '0;
   logic       go = 1'b0;
   logic       done = 1'b0;
   logic       secure_o, block_o, boot_o, derr_o, erase_o, busy_o;

   int checks = 0;
   int errors = 0;
   int cycles = 0;
   bit finished = 0;

   // reference model state
   int m_sec = 1, m_boot = 0, m_loaded = 0, m_div = 0, m_phase = 0, m_left = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   flash_guard #(.CLK_HZ(CLK_HZ), .ERASE_TICKS(ERASE_TICKS)) i_flash_guard (
      .clk(clk), .rst_n(rst_n), .sec_byte_i(sec_byte), .boot_ext_i(boot_pin),
      .dbg_instr_i(instr), .dbg_dr_load_i(dr_load), .dbg_dr_data_i(dr_data),
      .dbg_go_i(go), .erase_done_i(done),
      .secure_o(secure_o), .dbg_read_block_o(block_o), .boot_ext_o(boot_o),
      .div_err_o(derr_o), .erase_o(erase_o), .busy_o(busy_o));

   function automatic int per_of(int v);
      return ((v & 63) + 1) * (((v & 64) != 0) ? 8 : 1);
   endfunction

   function automatic int bad_div(int v);
      real f;
      f = real'(CLK_HZ) / real'(per_of(v));
      return ((f > 200000.0) || (f < 150000.0)) ? 1 : 0;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_sec = (sec_byte != OPEN) ? 1 : 0;
         m_boot = (boot_pin && sec_byte == OPEN) ? 1 : 0;
         m_loaded = 0; m_div = 0; m_phase = 0; m_left = 0;
      end else begin
         case (m_phase)
            0: begin
               if (instr == OP && go && m_loaded == 1 && bad_div(m_div) == 0) begin
                  m_phase = 1;
                  m_left = ERASE_TICKS * per_of(m_div);
               end else if (instr == OP && dr_load) begin
                  m_loaded = 1;
                  m_div = int'(dr_data);
               end
            end
            1: begin
               m_left = m_left - 1;
               if (m_left == 0) m_phase = 2;
            end
            2: if (done) m_phase = 3;
            default: begin
               m_sec = 0;
               m_phase = 0;
            end
         endcase
      end
   end

   task automatic check(input string tag, input logic act, input int exp);
      checks++;
      if (act !== exp[0]) begin
         errors++;
         $display("FAIL %s: actual %0b expected %0d at cycle %0d", tag, act, exp, cycles);
      end
   endtask

   // per-cycle comparison against the model, away from the active edge
   always @(negedge clk) begin
      cycles++;
      if (rst_n && !finished) begin
         check("R1/R8 secure_o", secure_o, m_sec);
         check("R1 dbg_read_block_o", block_o, m_sec);
         check("R2 boot_ext_o", boot_o, m_boot);
         check("R4 div_err_o", derr_o, (m_loaded == 1) ? bad_div(m_div) : 0);
         check("R6 erase_o", erase_o, (m_phase == 1) ? 1 : 0);
         check("R7 busy_o", busy_o, (m_phase != 0) ? 1 : 0);
      end
   end

   task automatic wait_cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic do_reset(input logic [7:0] sb, input logic bp);
      @(negedge clk);
      rst_n = 1'b0; sec_byte = sb; boot_pin = bp;
      wait_cyc(2);
      rst_n = 1'b1;
      wait_cyc(1);
   endtask

   task automatic load(input logic [3:0] ins, input logic [6:0] v);
      instr = ins; dr_data = v; dr_load = 1'b1;
      wait_cyc(1);
      dr_load = 1'b0;
      wait_cyc(1);
   endtask

   task automatic start(input logic [3:0] ins);
      instr = ins; go = 1'b1;
      wait_cyc(1);
      go = 1'b0;
      wait_cyc(1);
   endtask

   task automatic pulse_done();
      done = 1'b1;
      wait_cyc(1);
      done = 1'b0;
   endtask

   initial begin
      wait_cyc(1);
      // R1 R2: locked reset with boot pin high
      do_reset(8'h00, 1'b1);
      check("R1 reset locked", secure_o, 1);
      check("R2 boot ignored when locked", boot_o, 0);

      // R5: start with nothing stored
      start(OP);
      check("R5 start without load", busy_o, 0);

      // R3: load under another instruction is ignored
      load(4'h3, 7'h27);
      start(OP);
      check("R3 wrong instruction load", busy_o, 0);
      check("R3 div_err stays clear", derr_o, 0);

      // R4 R5: out-of-range divider (pre8, div 6 -> period 56)
      load(OP, 7'h46);
      check("R4 slow divider flagged", derr_o, 1);
      start(OP);
      check("R5 start rejected on bad divider", erase_o, 0);
      // R4 boundaries: period 54 bad, period 53 good
      load(OP, 7'd53);
      check("R4 period 54 out of range", derr_o, 1);
      load(OP, 7'd38);
      check("R4 period 39 out of range", derr_o, 1);
      load(OP, 7'd52);
      check("R4 period 53 in range", derr_o, 0);

      // R6 R7 R8: good divider, period 40, full recovery
      load(OP, 7'd39);
      start(OP);
      wait_cyc(20);
      pulse_done();                 // R7 stray completion during erase
      load(OP, 7'h46);              // R8 load while busy is ignored
      check("R8 load ignored while busy", derr_o, 0);
      wait_cyc(ERASE_TICKS * 40);
      check("R7 still locked while waiting", secure_o, 1);
      pulse_done();
      wait_cyc(3);
      check("R7 unlocked after done", secure_o, 0);
      check("R2 boot stays internal after unlock", boot_o, 0);

      // R1 R2: unlocked reset with boot pin high, prescaled divider run
      do_reset(OPEN, 1'b1);
      check("R1 reset unlocked", secure_o, 0);
      check("R2 external boot granted", boot_o, 1);
      load(OP, 7'h44);
      start(OP);
      wait_cyc(ERASE_TICKS * 40 + 5);
      pulse_done();
      wait_cyc(3);
      check("R7 sequence completes", busy_o, 0);

      // R1: locked again after reset
      do_reset(8'hFF, 1'b0);
      check("R1 relocked by reset", secure_o, 1);
      wait_cyc(3);

      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      wait (cycles > 20000);
      if (!finished) begin
         finished = 1;
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule